// File: doc/BRIEF.md
# Serial Frame Alignment Detector

This block sits right behind the serial line receiver of an STS-3 interface. It takes one raw bit per serial clock, which runs at roughly 150 MHz. It searches that stream for the six-byte alignment word that opens every frame: three copies of A1 followed by three copies of A2, one of each per interleaved STS-1. The search runs on the raw, still-scrambled bits. It slides a 48-bit window one bit at a time, so the word is found whatever its bit offset. When the window matches, the byte boundary is reset so that the next bit starts a fresh byte. From then on the block emits parallel bytes, which keeps the fast serial signal at a small fan-out and lets every later stage run at one eighth of the bit rate.

After the first hit, the block checks for the word again exactly one frame length later. It declares in-frame once enough of these checks succeed in a row. In-frame ends after a run of consecutive failures at the expected position. A start-of-frame pulse marks each accepted frame boundary. The byte strobe is a one-cycle enable in the serial clock domain; no clock is derived or gated. All outputs come straight from flops, and reset clears every register.

Top module: `sfa_framer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `data_o` is 0, `byte_stb_o` is 0, `sof_o` is 0 and `in_frame_o` is 0, and the block is searching.
- R2: While searching, a 48-bit window of the most recent bits (the first bit received is the MSB of each byte) is compared on every bit against F6 F6 F6 28 28 28, at any bit offset. A window that differs in a single bit is not accepted, and no byte strobe is produced while searching.
- R3: When the search accepts the word, the byte boundary is reloaded: the eight bits that follow the last alignment bit form the first output byte, with the earliest of them in bit 7 of `data_o`.
- R4: Outside the search, every group of eight bits yields one `byte_stb_o` pulse with that byte on `data_o`. This holds for payload bytes and for the alignment bytes of later frames alike, and `data_o` is updated in the same cycle as the strobe.
- R5: `sof_o` is a one-cycle pulse issued one cycle after an accepted frame boundary: a search hit, a confirmed hit, or, when locked, every frame boundary that does not end the lock. The next strobed byte after `sof_o` is the first byte after the alignment word.
- R6: After a search hit, the word is tested only at FRAME_BYTES*8 bit intervals. After LOCK_HITS consecutive successes there, `in_frame_o` goes to 1. A failure at that position before then returns the block to the search.
- R7: While locked, `in_frame_o` stays 1 until LOSE_MISSES consecutive frame boundaries fail, then falls as the block returns to the search and stops strobing bytes. A success in between clears the failure count.
- R8: `byte_stb_o` and `sof_o` are never high for two cycles in a row, and consecutive byte strobes are at least eight cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Serial data bit, one per clock |
| data_o | output | 8 | Aligned parallel byte |
| byte_stb_o | output | 1 | One-cycle enable marking a new byte on data_o |
| sof_o | output | 1 | One-cycle start-of-frame pulse |
| in_frame_o | output | 1 | High while frame alignment is locked |

## Verification
The bench builds the block with FRAME_BYTES set to 16, and LOCK_HITS (2) and LOSE_MISSES (4) left at their defaults. The short frame puts lock entry, the four-frame loss of lock, a miss count broken by a single good frame, and a fresh search at a new bit offset within a few thousand cycles. The shape of the word and the confirmation counts stay as the default build has them. Corrupted frames carry an alignment word that is off by one bit, so both the search compare and the confirmation compare are tested against a near miss.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int SFA_BYTE_W = 8;
    localparam logic [SFA_BYTE_W-1:0] SFA_A1_DEF = 8'hF6;
    localparam logic [SFA_BYTE_W-1:0] SFA_A2_DEF = 8'h28;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_SYNC = 2'd2
    } sfa_state_e;

    typedef struct packed {
        logic [SFA_BYTE_W-1:0] data;
        logic                  stb;
        logic                  sof;
    } sfa_out_t;

    function automatic int sfa_cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sfa_bit_window.sv
module sfa_bit_window
    import sfa_pkg::*;
#(
    parameter int                    N_STS = 3,
    parameter logic [SFA_BYTE_W-1:0] A1    = SFA_A1_DEF,
    parameter logic [SFA_BYTE_W-1:0] A2    = SFA_A2_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdata_i,
    output logic [SFA_BYTE_W-2:0] recent_o,
    output logic                  hit_o
);
    localparam int PAT_BYTES = 2 * N_STS;
    localparam int WIN_W     = SFA_BYTE_W * PAT_BYTES;

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] pat;

    for (genvar g = 0; g < PAT_BYTES; g++) begin : g_pat
        if (g < N_STS) begin : g_a1
            assign pat[WIN_W-1-SFA_BYTE_W*g -: SFA_BYTE_W] = A1;
        end else begin : g_a2
            assign pat[WIN_W-1-SFA_BYTE_W*g -: SFA_BYTE_W] = A2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= {win_q[WIN_W-2:0], sdata_i};
        end
    end

    assign hit_o    = (win_q == pat);
    assign recent_o = win_q[SFA_BYTE_W-2:0];

endmodule

// File: rtl/sfa_byte_timer.sv
module sfa_byte_timer
    import sfa_pkg::*;
#(
    parameter int FRAME_BYTES = 2430,
    parameter int N_STS       = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic reload_i,
    output logic last_bit_o,
    output logic at_mark_o
);
    localparam int PAT_BYTES = 2 * N_STS;
    localparam int BIT_W     = $clog2(SFA_BYTE_W);
    localparam int IDX_W     = $clog2(FRAME_BYTES);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SFA_BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_MARK = IDX_W'(PAT_BYTES);

    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
            idx_q <= '0;
        end else if (reload_i) begin
            // the bit sampled at this edge is bit 0 of the first payload byte
            bit_q <= BIT_W'(1);
            idx_q <= IDX_MARK;
        end else if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end else begin
            bit_q <= bit_q + 1'b1;
        end
    end

    assign last_bit_o = (bit_q == BIT_LAST);
    assign at_mark_o  = (bit_q == '0) && (idx_q == IDX_MARK);

    AST_MARK_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        at_mark_o |=> !at_mark_o) else $error("mark repeated");  // R6

endmodule

// File: rtl/sfa_sync_fsm.sv
module sfa_sync_fsm
    import sfa_pkg::*;
#(
    parameter int LOCK_HITS   = 2,
    parameter int LOSE_MISSES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_i,
    input  logic       at_mark_i,
    output sfa_state_e state_o,
    output logic       reload_o,
    output logic       sof_evt_o,
    output logic       lock_o
);
    localparam int HIT_W  = sfa_cnt_width(LOCK_HITS);
    localparam int MISS_W = sfa_cnt_width(LOSE_MISSES);
    localparam logic [HIT_W-1:0]  HIT_FINAL  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_FINAL = MISS_W'(LOSE_MISSES - 1);

    sfa_state_e        state_q, state_n;
    logic [HIT_W-1:0]  hits_q, hits_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic              lock_q;

    always_comb begin
        state_n   = state_q;
        hits_n    = hits_q;
        miss_n    = miss_q;
        reload_o  = 1'b0;
        sof_evt_o = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (hit_i) begin
                    reload_o  = 1'b1;
                    sof_evt_o = 1'b1;
                    hits_n    = '0;
                    state_n   = ST_PRE;
                end
            end
            ST_PRE: begin
                if (at_mark_i) begin
                    if (hit_i) begin
                        sof_evt_o = 1'b1;
                        if (hits_q == HIT_FINAL) begin
                            state_n = ST_SYNC;
                            miss_n  = '0;
                        end else begin
                            hits_n = hits_q + 1'b1;
                        end
                    end else begin
                        state_n = ST_HUNT;
                    end
                end
            end
            ST_SYNC: begin
                if (at_mark_i) begin
                    if (hit_i) begin
                        miss_n    = '0;
                        sof_evt_o = 1'b1;
                    end else if (miss_q == MISS_FINAL) begin
                        state_n = ST_HUNT;
                    end else begin
                        miss_n    = miss_q + 1'b1;
                        sof_evt_o = 1'b1;
                    end
                end
            end
            default: state_n = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            hits_q  <= '0;
            miss_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            hits_q  <= hits_n;
            miss_q  <= miss_n;
            lock_q  <= (state_n == ST_SYNC);
        end
    end

    assign state_o = state_q;
    assign lock_o  = lock_q;

    AST_LOCK_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> ($past(state_q) == ST_PRE)) else $error("lock skipped confirm");  // R6
    AST_LOSS_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> (state_q == ST_HUNT)) else $error("loss not to hunt");  // R7

endmodule

// File: rtl/sfa_framer.sv
module sfa_framer
    import sfa_pkg::*;
#(
    parameter int                    FRAME_BYTES = 2430,
    parameter int                    N_STS       = 3,
    parameter logic [SFA_BYTE_W-1:0] A1          = SFA_A1_DEF,
    parameter logic [SFA_BYTE_W-1:0] A2          = SFA_A2_DEF,
    parameter int                    LOCK_HITS   = 2,
    parameter int                    LOSE_MISSES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdata_i,
    output logic [SFA_BYTE_W-1:0] data_o,
    output logic                  byte_stb_o,
    output logic                  sof_o,
    output logic                  in_frame_o
);
    logic [SFA_BYTE_W-2:0] recent;
    logic                  hit;
    logic                  last_bit;
    logic                  at_mark;
    logic                  reload;
    logic                  sof_evt;
    logic                  lock;
    sfa_state_e            state;
    sfa_out_t              out_q;

    sfa_bit_window #(.N_STS(N_STS), .A1(A1), .A2(A2)) u_window (
        .clk      (clk),
        .rst      (rst),
        .sdata_i  (sdata_i),
        .recent_o (recent),
        .hit_o    (hit)
    );

    sfa_byte_timer #(.FRAME_BYTES(FRAME_BYTES), .N_STS(N_STS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .reload_i   (reload),
        .last_bit_o (last_bit),
        .at_mark_o  (at_mark)
    );

    sfa_sync_fsm #(.LOCK_HITS(LOCK_HITS), .LOSE_MISSES(LOSE_MISSES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit_i     (hit),
        .at_mark_i (at_mark),
        .state_o   (state),
        .reload_o  (reload),
        .sof_evt_o (sof_evt),
        .lock_o    (lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.sof <= sof_evt;
            out_q.stb <= 1'b0;
            if (last_bit && (state != ST_HUNT)) begin
                out_q.data <= {recent, sdata_i};
                out_q.stb  <= 1'b1;
            end
        end
    end

    assign data_o     = out_q.data;
    assign byte_stb_o = out_q.stb;
    assign sof_o      = out_q.sof;
    assign in_frame_o = lock;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_stb_o |=> !byte_stb_o) else $error("strobe too long");  // R8
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sof_o |=> !sof_o) else $error("sof too long");  // R5
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && $past(state) == ST_HUNT) |-> !byte_stb_o) else $error("strobe while hunting");  // R2

endmodule

// File: tb/sfa_framer_tb.sv
module sfa_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FB         = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       sdata;
    logic [7:0] data_o;
    logic       byte_stb_o, sof_o, in_frame_o;

    int         n_vec = 0;
    int         n_bad = 0;
    int         sof_seen = 0;
    int         cyc = 0;
    int         last_stb = -100;
    bit         want_first = 1'b0;
    logic [7:0] exp_q[$];

    sfa_framer #(.FRAME_BYTES(FB)) u_dut (
        .clk(clk), .rst(rst), .sdata_i(sdata),
        .data_o(data_o), .byte_stb_o(byte_stb_o), .sof_o(sof_o), .in_frame_o(in_frame_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdata = b;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit push);
        if (push) exp_q.push_back(v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // good=0 gives an alignment word whose last byte is off by one bit
    task automatic send_frame(input int fn, input bit good, input int lo, input int hi);
        for (int i = 0; i < FB; i++) begin
            logic [7:0] v;
            if (i < 3)       v = 8'hF6;
            else if (i < 5)  v = 8'h28;
            else if (i == 5) v = good ? 8'h28 : 8'h29;
            else if (i == 6) v = 8'hA5;
            else             v = {fn[3:0], 4'(i)};
            send_byte(v, (i >= lo) && (i <= hi));
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sof_o) begin
                sof_seen++;
                want_first = 1'b1;
            end
            if (byte_stb_o) begin
                chk(cyc - last_stb >= 8, "R8 strobe spacing", cyc - last_stb, 8);
                last_stb = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 strobe with no byte expected", data_o, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(data_o == e, "R4 byte value", data_o, e);
                end
                if (want_first) begin
                    chk(data_o == 8'hA5, "R5 first byte after sof", data_o, 8'hA5);
                    want_first = 1'b0;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int s0;
        rst = 1'b1;
        sdata = 1'b0;
        repeat (4) @(negedge clk);
        chk(data_o == 8'h00, "R1 data after reset", data_o, 0);
        chk(byte_stb_o == 1'b0, "R1 strobe after reset", byte_stb_o, 0);
        chk(sof_o == 1'b0, "R1 sof after reset", sof_o, 0);
        chk(in_frame_o == 1'b0, "R1 in_frame after reset", in_frame_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_frame_o == 1'b0 && byte_stb_o == 1'b0, "R1 first cycle out of reset", in_frame_o, 0);

        // search at offset 5, first hit then confirmations
        repeat (5) send_bit(1'b0);
        send_frame(0, 1'b1, 6, FB - 1);     // R3 first byte after word
        send_frame(1, 1'b1, 0, FB - 1);
        chk(in_frame_o == 1'b0, "R6 not locked after one confirm", in_frame_o, 0);
        send_frame(2, 1'b1, 0, FB - 1);
        chk(in_frame_o == 1'b1, "R6 locked after two confirms", in_frame_o, 1);

        // misses broken by one good frame keep the lock
        for (int f = 0; f < 3; f++) send_frame(3 + f, 1'b0, 0, FB - 1);
        chk(in_frame_o == 1'b1, "R7 lock kept after three misses", in_frame_o, 1);
        send_frame(6, 1'b1, 0, FB - 1);
        for (int f = 0; f < 3; f++) send_frame(7 + f, 1'b0, 0, FB - 1);
        chk(in_frame_o == 1'b1, "R7 miss count cleared by a hit", in_frame_o, 1);
        send_frame(10, 1'b0, 0, 5);
        chk(in_frame_o == 1'b0, "R7 lock lost after four misses", in_frame_o, 0);

        // near miss while searching must not be taken
        s0 = sof_seen;
        send_frame(11, 1'b0, 99, 99);
        chk(sof_seen == s0, "R2 near miss ignored while searching", sof_seen, s0);
        chk(in_frame_o == 1'b0, "R2 still searching", in_frame_o, 0);

        // new bit offset, then a failed confirm sends it back to search
        repeat (3) send_bit(1'b0);
        send_frame(12, 1'b1, 6, FB - 1);
        send_frame(13, 1'b0, 0, 5);
        chk(in_frame_o == 1'b0, "R6 failed confirm returns to search", in_frame_o, 0);
        send_frame(14, 1'b1, 6, FB - 1);
        send_frame(15, 1'b1, 0, FB - 1);
        chk(in_frame_o == 1'b0, "R6 one confirm only", in_frame_o, 0);
        send_frame(1, 1'b0, 0, 5);
        repeat (40) send_bit(1'b0);

        chk(exp_q.size() == 0, "R4 all expected bytes strobed", exp_q.size(), 0);
        chk(sof_seen == 13, "R5 start-of-frame count", sof_seen, 13);
        chk(in_frame_o == 1'b0, "R7 ends out of frame", in_frame_o, 0);
        finish_run();
    end

endmodule